// File: doc/BRIEF.md
# Periodic PC Synchronization Trace Generator

This block sits beside a processor's trace port and inserts instruction-address anchors into the trace stream at a programmable rate. While enabled, it counts core clock cycles. Each time the selected interval runs out, it raises a sync request that makes the CPU refetch its next instruction. When the CPU acknowledges, it also presents that instruction's address. The block then serializes a short packet on a 4-bit trace output: a taken-branch status nibble, a length marker, and the address, least significant nibble first.

The interval is set by a 2-bit select and a divide-by-16 bit. The period in cycles is 2^(SEL+1) x 1024, divided by 16 when the divide bit is set. The address-size input picks between a 2-byte and a 3-byte address. That input is latched together with the address at the acknowledge.

The control FSM has five states. **IDLE** waits for an expiry and goes to **REQ** when one occurs. **REQ** holds the sync request until `cpu_ack` and then goes to **STAT**. **STAT** emits the status nibble and always goes to **MARK**. **MARK** emits the length marker and always goes to **ADDR**. **ADDR** emits one address nibble per cycle and returns to IDLE after the last nibble.

Top module: `pcsync_trace_gen`

## Requirements
- R1: After reset, `sync_req` is 0, `trace_vld` is 0 and `trace_nib` is 0x0.
- R2: While `enable` is 0, `sync_req` never rises.
- R3: With `div16`=0, `sel` values 0, 1, 2 and 3 give request periods of 2048, 4096, 8192 and 16384 cycles. The period is measured between successive rising edges of `sync_req`.
- R4: With `div16`=1, `sel` values 0, 1, 2 and 3 give request periods of 128, 256, 512 and 1024 cycles.
- R5: A change on `enable`, `sel` or `div16` restarts the count. The first request then rises exactly one period after the clock edge that samples the change. Issuing a request also restarts the count.
- R6: `sync_req` stays high until a cycle with `cpu_ack` high, and is low in the cycle after that one.
- R7: In the cycle after the acknowledge, `trace_vld`=1 with nibble 0x5. The next cycle carries the marker: 0x9 for a 2-byte address, 0xA for a 3-byte address.
- R8: After the marker come the address nibbles, least significant first. There are 4 nibbles (`cpu_addr[15:0]`) when `addr_wide` was 0 at the acknowledge, and 6 nibbles (`cpu_addr[23:0]`) when it was 1.
- R9: `trace_vld` is high for exactly one cycle per packet nibble, with no gaps inside a packet. Whenever `trace_vld` is 0, `trace_nib` is 0x0.
- R10: An expiry that falls while a request is outstanding or a packet is being sent is dropped. The next request comes at the following period boundary, counted from the previous request's issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Periodic sync enable |
| sel | input | 2 | Interval select |
| div16 | input | 1 | Divides the interval by 16 |
| addr_wide | input | 1 | 0: 2-byte address, 1: 3-byte address (sampled at acknowledge) |
| cpu_ack | input | 1 | CPU acknowledge of the sync request, address valid |
| cpu_addr | input | 24 | Address of the refetched instruction |
| sync_req | output | 1 | Forced-refetch request to the CPU |
| trace_nib | output | 4 | Trace nibble |
| trace_vld | output | 1 | Trace nibble valid |

## Verification
On every cycle, the assertions check the request handshake: the request is held without an acknowledge, drops after one, and never rises while disabled. They also check that the packet starts with 0x5 followed by the correct marker, that the idle nibble is zero, and that no request overlaps a packet. Only the bench scenarios can show the interval lengths for each select and divide setting, the restart on a configuration change, and the address nibble order and count. The same goes for dropping an expiry that lands inside a long handshake, since each of these needs cycle counts or data comparisons spanning thousands of cycles.

// File: rtl/pcsync_pkg.sv
package pcsync_pkg;
    localparam int unsigned PCS_SEL_W      = 2;
    localparam int unsigned PCS_BASE_SHIFT = 10;
    localparam int unsigned PCS_FAST_SHIFT = 4;
    localparam int unsigned PCS_CNT_W      = PCS_BASE_SHIFT + (1 << PCS_SEL_W);
    localparam int unsigned PCS_ADDR_W     = 24;
    localparam int unsigned PCS_NIB_W      = 4;

    localparam logic [3:0] PCS_NIB_IDLE  = 4'h0;
    localparam logic [3:0] PCS_NIB_TAKEN = 4'h5;
    localparam logic [3:0] PCS_NIB_LEN2  = 4'h9;
    localparam logic [3:0] PCS_NIB_LEN3  = 4'hA;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_STAT,
        ST_MARK,
        ST_ADDR
    } pcs_state_e;
endpackage

// File: rtl/pcsync_timer.sv
module pcsync_timer #(
    parameter int unsigned SEL_W      = 2,
    parameter int unsigned BASE_SHIFT = 10,
    parameter int unsigned FAST_SHIFT = 4,
    parameter int unsigned CNT_W      = BASE_SHIFT + (1 << SEL_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [SEL_W-1:0] sel,
    input  logic             div16,
    output logic             expire
);
    localparam int unsigned NSEL  = 1 << SEL_W;
    localparam int unsigned CFG_W = SEL_W + 2;

    logic [CNT_W-1:0] lim_slow [NSEL];
    logic [CNT_W-1:0] lim_fast [NSEL];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic [CFG_W-1:0] cfg_q;
    logic [CFG_W-1:0] cfg_now;
    logic             changed;
    logic             hit;

    for (genvar g = 0; g < NSEL; g++) begin : g_lim
        assign lim_slow[g] = CNT_W'((64'd1 << (BASE_SHIFT + 1 + g)) - 64'd1);
        assign lim_fast[g] = CNT_W'((64'd1 << (BASE_SHIFT + 1 + g - FAST_SHIFT)) - 64'd1);
    end

    assign cfg_now = {enable, div16, sel};
    assign changed = (cfg_now != cfg_q);
    assign limit   = div16 ? lim_fast[sel] : lim_slow[sel];
    assign hit     = enable && !changed && (cnt_q == limit);
    assign expire  = hit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_now;
            if (changed || !enable || hit) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/pcsync_nibbler.sv
module pcsync_nibbler #(
    parameter int unsigned ADDR_W = 24,
    parameter int unsigned NIB_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              wide_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              step,
    output logic [NIB_W-1:0]  nib,
    output logic              wide,
    output logic              last
);
    localparam int unsigned NIBS        = ADDR_W / NIB_W;
    localparam int unsigned NARROW_NIBS = (ADDR_W - 8) / NIB_W;
    localparam int unsigned IDX_W       = $clog2(NIBS);
    localparam int unsigned SLOTS       = 1 << IDX_W;

    logic [ADDR_W-1:0] addr_q;
    logic              wide_q;
    logic [IDX_W-1:0]  idx_q;
    logic [NIB_W-1:0]  nib_arr [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_nib
        if (g < NIBS) begin : g_real
            assign nib_arr[g] = addr_q[g*NIB_W +: NIB_W];
        end else begin : g_pad
            assign nib_arr[g] = '0;
        end
    end

    assign nib  = nib_arr[idx_q];
    assign wide = wide_q;
    assign last = wide_q ? (idx_q == IDX_W'(NIBS - 1))
                         : (idx_q == IDX_W'(NARROW_NIBS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            wide_q <= 1'b0;
            idx_q  <= '0;
        end else if (load) begin
            addr_q <= addr_in;
            wide_q <= wide_in;
            idx_q  <= '0;
        end else if (step) begin
            idx_q  <= idx_q + IDX_W'(1);
        end
    end
endmodule

// File: rtl/pcsync_trace_gen.sv
module pcsync_trace_gen
    import pcsync_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic [PCS_SEL_W-1:0]  sel,
    input  logic                  div16,
    input  logic                  addr_wide,
    input  logic                  cpu_ack,
    input  logic [PCS_ADDR_W-1:0] cpu_addr,
    output logic                  sync_req,
    output logic [PCS_NIB_W-1:0]  trace_nib,
    output logic                  trace_vld
);
    pcs_state_e           state_q;
    pcs_state_e           state_d;
    logic                 expire;
    logic                 load;
    logic                 step;
    logic [PCS_NIB_W-1:0] addr_nib;
    logic                 wide_q;
    logic                 last_nib;

    pcsync_timer #(
        .SEL_W      (PCS_SEL_W),
        .BASE_SHIFT (PCS_BASE_SHIFT),
        .FAST_SHIFT (PCS_FAST_SHIFT),
        .CNT_W      (PCS_CNT_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .sel    (sel),
        .div16  (div16),
        .expire (expire)
    );

    assign load = (state_q == ST_REQ) && cpu_ack;
    assign step = (state_q == ST_ADDR);

    pcsync_nibbler #(
        .ADDR_W (PCS_ADDR_W),
        .NIB_W  (PCS_NIB_W)
    ) u_nibbler (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .wide_in (addr_wide),
        .addr_in (cpu_addr),
        .step    (step),
        .nib     (addr_nib),
        .wide    (wide_q),
        .last    (last_nib)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (expire)   state_d = ST_REQ;
            ST_REQ:  if (cpu_ack)  state_d = ST_STAT;
            ST_STAT:               state_d = ST_MARK;
            ST_MARK:               state_d = ST_ADDR;
            ST_ADDR: if (last_nib) state_d = ST_IDLE;
            default:               state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        sync_req  = 1'b0;
        trace_vld = 1'b0;
        trace_nib = PCS_NIB_IDLE;
        unique case (state_q)
            ST_IDLE: ;
            ST_REQ:  sync_req = 1'b1;
            ST_STAT: begin
                trace_vld = 1'b1;
                trace_nib = PCS_NIB_TAKEN;
            end
            ST_MARK: begin
                trace_vld = 1'b1;
                trace_nib = wide_q ? PCS_NIB_LEN3 : PCS_NIB_LEN2;
            end
            ST_ADDR: begin
                trace_vld = 1'b1;
                trace_nib = addr_nib;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pcsync_trace_gen_chk.sv
module pcsync_trace_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       enable,
    input logic       addr_wide,
    input logic       cpu_ack,
    input logic       sync_req,
    input logic [3:0] trace_nib,
    input logic       trace_vld
);
    p_no_rise_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !$rose(sync_req));

    p_req_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_req && !cpu_ack) |=> sync_req);

    p_req_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_req && cpu_ack) |=> !sync_req);

    p_status_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_req && cpu_ack) |=> (trace_vld && trace_nib == 4'h5));

    p_marker_wide_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_req && cpu_ack && addr_wide) |=> ##1 (trace_vld && trace_nib == 4'hA));

    p_marker_narrow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_req && cpu_ack && !addr_wide) |=> ##1 (trace_vld && trace_nib == 4'h9));

    p_idle_nib_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !trace_vld |-> (trace_nib == 4'h0));

    p_no_req_in_pkt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        trace_vld |-> !sync_req);
endmodule

bind pcsync_trace_gen pcsync_trace_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .addr_wide (addr_wide),
    .cpu_ack   (cpu_ack),
    .sync_req  (sync_req),
    .trace_nib (trace_nib),
    .trace_vld (trace_vld)
);

// File: tb/pcsync_trace_gen_test.sv
module pcsync_trace_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [1:0]  sel = 2'd0;
    logic        div16 = 1'b0;
    logic        addr_wide = 1'b0;
    logic        cpu_ack = 1'b0;
    logic [23:0] cpu_addr = 24'd0;
    logic        sync_req;
    logic [3:0]  trace_nib;
    logic        trace_vld;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pcsync_trace_gen uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .sel(sel), .div16(div16),
        .addr_wide(addr_wide), .cpu_ack(cpu_ack), .cpu_addr(cpu_addr),
        .sync_req(sync_req), .trace_nib(trace_nib), .trace_vld(trace_vld)
    );

    function automatic int exp_period(input logic [1:0] s, input logic d);
        int p;
        p = (2 ** (int'(s) + 1)) * 1024;
        return d ? p / 16 : p;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        if (cyc == 190000 && !done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
            summary();
            $finish;
        end
    end

    // Disable for one cycle, then apply the new setting; returns the cycle
    // count at the negedge where the new setting was driven.
    task automatic set_cfg(input logic [1:0] s, input logic d, output int c0);
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        enable = 1'b1;
        sel = s;
        div16 = d;
        c0 = cyc;
    endtask

    task automatic wait_rise(output int c);
        @(negedge clk);
        while (!sync_req) @(negedge clk);
        c = cyc;
    endtask

    // Called at a negedge with sync_req high.
    task automatic handshake(input int delay, input logic [23:0] a, input logic w);
        bit held = 1'b1;
        int nn;
        for (int d = 0; d < delay; d++) begin
            @(negedge clk);
            if (!sync_req) held = 1'b0;
        end
        chk("R6 request held", int'(held), 1);
        cpu_ack = 1'b1;
        cpu_addr = a;
        addr_wide = w;
        @(negedge clk);
        cpu_ack = 1'b0;
        addr_wide = ~w;
        cpu_addr = ~a;
        chk("R6 request dropped", int'(sync_req), 0);
        chk("R7 status nibble", int'({trace_vld, trace_nib}), 'h15);
        @(negedge clk);
        chk("R7 length marker", int'({trace_vld, trace_nib}), w ? 'h1A : 'h19);
        nn = w ? 6 : 4;
        for (int i = 0; i < nn; i++) begin
            @(negedge clk);
            chk("R8 address nibble", int'({trace_vld, trace_nib}), int'({1'b1, a[i*4 +: 4]}));
        end
        @(negedge clk);
        chk("R9 idle after packet", int'({trace_vld, trace_nib}), 0);
    endtask

    initial begin
        int c0, r1, r2;
        bit quiet;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        chk("R1 reset sync_req", int'(sync_req), 0);
        chk("R1 reset trace", int'({trace_vld, trace_nib}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", int'({sync_req, trace_vld, trace_nib}), 0);

        // R2: disabled, fastest setting, well beyond a period
        div16 = 1'b1;
        sel = 2'd0;
        quiet = 1'b1;
        repeat (3000) begin
            @(negedge clk);
            if (sync_req) quiet = 1'b0;
        end
        chk("R2 no request while disabled", int'(quiet), 1);

        // R3: slow intervals, first request after the change edge
        for (int s = 0; s < 4; s++) begin
            set_cfg(2'(s), 1'b0, c0);
            wait_rise(r1);
            chk("R3 slow period", r1 - c0 - 1, exp_period(2'(s), 1'b0));
            handshake(1, 24'h00A5C3 + 24'(s), 1'b0);
        end

        // R4: fast intervals, request to request
        for (int s = 0; s < 4; s++) begin
            set_cfg(2'(s), 1'b1, c0);
            wait_rise(r1);
            handshake(0, 24'h3C1E0F, 1'b1);
            wait_rise(r2);
            chk("R4 fast period", r2 - r1, exp_period(2'(s), 1'b1));
            handshake(2, 24'h123456, 1'b0);
        end

        // R5: change select mid-interval restarts the count
        set_cfg(2'd1, 1'b1, c0);
        repeat (100) @(negedge clk);
        sel = 2'd0;
        c0 = cyc;
        wait_rise(r1);
        chk("R5 restart on select change", r1 - c0 - 1, 128);
        handshake(0, 24'hFEDCBA, 1'b1);

        // R10: expiry during a long-held request is dropped
        set_cfg(2'd0, 1'b1, c0);
        wait_rise(r1);
        handshake(200, 24'h0F0F0F, 1'b1);
        wait_rise(r2);
        chk("R10 dropped expiry", r2 - r1, 256);
        handshake(0, 24'h000001, 1'b0);

        // Random trials, fast settings
        for (int t = 0; t < 20; t++) begin
            logic [1:0] s;
            logic [23:0] a;
            logic w;
            s = 2'($urandom_range(0, 3));
            a = 24'($urandom());
            w = 1'($urandom_range(0, 1));
            set_cfg(s, 1'b1, c0);
            wait_rise(r1);
            chk("R5 random first request", r1 - c0 - 1, exp_period(s, 1'b1));
            handshake($urandom_range(0, 6), a, w);
            wait_rise(r2);
            chk("R4 random period", r2 - r1, exp_period(s, 1'b1));
            handshake($urandom_range(0, 6), ~a, ~w);
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule